// File: doc/BRIEF.md
# Charge Status Indicator Driver

This block turns the charge-state code from a battery-charge sequencer into two status pin controls. Each pin control is a drive level plus an output enable, ready for a pad cell. The indicators are active low: a lit LED is a pin pulled low.

One build-time parameter selects the indicator arrangement:
- a single LED;
- a red/green pair of separate LEDs, whose pins are open-drain;
- one bicolor LED, whose pins are push-pull.

A fault is shown with a 1 Hz, 50 percent blink on the red pin in the first two arrangements. The bicolor arrangement shows a fault as a steady mix of both colours instead.

The blink comes from a counter clocked by the system clock. A parameter sets the half period in clock cycles; the default gives 0.5 s at 125 MHz. The pin controls are registered, so every change of the state code shows up at the pins one clock later.

Top module: `chg_status_led`

## Requirements
- R1: The state code is 3 bits: 0 sleep, 1 precharge, 2 fast charge, 3 done, 4 fault, 5 qualification invalid, 6 thermal shutdown, 7 battery absent. The pin controls reflect the code sampled at a rising edge from just after that edge until the next one.
- R2: While reset is high, both indications are unlit after the next rising edge. In push-pull builds that means level 1 with enable 1; in the open-drain build it means enable 0.
- R3: Single-LED build (VARIANT = LED_SINGLE):
  - pin 1 is lit in precharge and fast charge;
  - pin 1 blinks in fault;
  - pin 1 is unlit in every other state;
  - pin 2 is never lit.
- R4: Two-LED build (VARIANT = LED_DUAL):
  - pin 1 (red) is lit in precharge and fast charge and blinks in fault;
  - pin 2 (green) is lit only in done;
  - at most one of the two pins is lit at a time.
- R5: Bicolor build (VARIANT = LED_BICOLOR):
  - both pins are lit steadily in fault, with no blinking;
  - only pin 2 is lit in done;
  - only pin 1 is lit in precharge and fast charge.
- R6: In sleep, qualification invalid, thermal shutdown and battery absent, both pins are unlit in every build.
- R7: A blinking pin is lit for BLINK_HALF clock cycles, then unlit for BLINK_HALF cycles, and repeats while the fault code is held. The default BLINK_HALF of 62,500,000 cycles at 125 MHz gives 1 Hz.
- R8: Each time the fault code is entered, the blink restarts at the beginning of its lit phase.
- R9: Push-pull builds (single and bicolor) hold both enables at 1. Each level is 0 when lit and 1 when unlit.
- R10: The open-drain build (two-LED) holds both levels at 0. Each enable is 1 only while its pin is lit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| state_i | input | 3 | Charge-state code from the sequencer |
| pin1_o | output | 1 | Pin 1 (red / single LED) drive level |
| pin1_oe | output | 1 | Pin 1 output enable |
| pin2_o | output | 1 | Pin 2 (green) drive level |
| pin2_oe | output | 1 | Pin 2 output enable |

## Verification
On every cycle, the embedded properties check the following:
- the one-clock path from the state code to the pins for charging, done and off codes;
- the unlit state after reset;
- the steady two-colour fault;
- that the blink phase moves only when its counter wraps;
- the lit start of the fault indication.

The bench runs all three builds side by side with a short blink period. Only its scenarios can show the exact blink waveform over many half periods, the restart after a short fault burst, and the full pin encoding under random runs of states. Each of those is compared against a per-cycle model of the requirements.

// File: rtl/chg_led_pkg.sv
package chg_led_pkg;

    typedef enum logic [1:0] {
        LED_SINGLE  = 2'd0,
        LED_DUAL    = 2'd1,
        LED_BICOLOR = 2'd2
    } led_variant_e;

    typedef enum logic [2:0] {
        CS_SLEEP    = 3'd0,
        CS_PRECHG   = 3'd1,
        CS_FAST     = 3'd2,
        CS_DONE     = 3'd3,
        CS_FAULT    = 3'd4,
        CS_QUAL_BAD = 3'd5,
        CS_THERM_SD = 3'd6,
        CS_NO_BATT  = 3'd7
    } chg_state_e;

    typedef struct packed {
        logic red;
        logic green;
    } lit_t;

    function automatic logic is_open_drain(led_variant_e v);
        return v == LED_DUAL;
    endfunction

    function automatic logic is_charging(chg_state_e s);
        return (s == CS_PRECHG) || (s == CS_FAST);
    endfunction

    function automatic lit_t lit_map(led_variant_e v, chg_state_e s, logic blink_on);
        lit_t r;
        r = '0;
        unique case (v)
            LED_SINGLE: begin
                r.red   = is_charging(s) || ((s == CS_FAULT) && blink_on);
                r.green = 1'b0;
            end
            LED_DUAL: begin
                r.red   = is_charging(s) || ((s == CS_FAULT) && blink_on);
                r.green = (s == CS_DONE);
            end
            LED_BICOLOR: begin
                r.red   = is_charging(s) || (s == CS_FAULT);
                r.green = (s == CS_DONE) || (s == CS_FAULT);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chg_blink_gen.sv
module chg_blink_gen #(
    parameter int unsigned HALF_CYCLES = 62_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic on_o
);
    localparam int unsigned CW = $clog2(HALF_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt_q   <= '0;
            phase_q <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign on_o = phase_q;

    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && cnt_q != LAST) |=> $stable(phase_q)); // R7
    AST_BLINK_FLIP: assert property (@(posedge clk) disable iff (rst)
        (active && cnt_q == LAST) |=> (phase_q != $past(phase_q))); // R7

endmodule

// File: rtl/chg_led_map.sv
module chg_led_map
    import chg_led_pkg::*;
#(
    parameter led_variant_e VARIANT = LED_SINGLE
) (
    input  chg_state_e state_i,
    input  logic       blink_on,
    output lit_t       lit_o
);
    always_comb begin
        lit_o = lit_map(VARIANT, state_i, blink_on);
    end
endmodule

// File: rtl/chg_pin_stage.sv
module chg_pin_stage
    import chg_led_pkg::*;
#(
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  lit_t lit_i,
    output logic p1_o,
    output logic p1_oe,
    output logic p2_o,
    output logic p2_oe
);
    generate
        if (OPEN_DRAIN) begin : g_od
            // Released pin: enable low; lit pin: driven to 0.
            always_ff @(posedge clk) begin
                if (rst) begin
                    p1_oe <= 1'b0;
                    p2_oe <= 1'b0;
                end else begin
                    p1_oe <= lit_i.red;
                    p2_oe <= lit_i.green;
                end
            end
            assign p1_o = 1'b0;
            assign p2_o = 1'b0;
        end else begin : g_pp
            always_ff @(posedge clk) begin
                if (rst) begin
                    p1_o <= 1'b1;
                    p2_o <= 1'b1;
                end else begin
                    p1_o <= ~lit_i.red;
                    p2_o <= ~lit_i.green;
                end
            end
            assign p1_oe = 1'b1;
            assign p2_oe = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/chg_status_led.sv
module chg_status_led
    import chg_led_pkg::*;
#(
    parameter led_variant_e VARIANT    = LED_SINGLE,
    parameter int unsigned  BLINK_HALF = 62_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] state_i,
    output logic       pin1_o,
    output logic       pin1_oe,
    output logic       pin2_o,
    output logic       pin2_oe
);
    localparam bit OD = is_open_drain(VARIANT);

    chg_state_e st;
    logic       blink_on;
    lit_t       lit;

    assign st = chg_state_e'(state_i);

    chg_blink_gen #(.HALF_CYCLES(BLINK_HALF)) u_blink (
        .clk    (clk),
        .rst    (rst),
        .active (st == CS_FAULT),
        .on_o   (blink_on)
    );

    chg_led_map #(.VARIANT(VARIANT)) u_map (
        .state_i  (st),
        .blink_on (blink_on),
        .lit_o    (lit)
    );

    chg_pin_stage #(.OPEN_DRAIN(OD)) u_pins (
        .clk   (clk),
        .rst   (rst),
        .lit_i (lit),
        .p1_o  (pin1_o),
        .p1_oe (pin1_oe),
        .p2_o  (pin2_o),
        .p2_oe (pin2_oe)
    );

    // Lit view of the pins, taken from the ports.
    logic p1_lit, p2_lit;
    assign p1_lit = OD ? pin1_oe : !pin1_o;
    assign p2_lit = OD ? pin2_oe : !pin2_o;

    AST_RESET_OFF: assert property (@(posedge clk)
        rst |=> (!p1_lit && !p2_lit)); // R2
    AST_CHARGING_RED: assert property (@(posedge clk) disable iff (rst)
        (state_i == 3'd1 || state_i == 3'd2) |=> (p1_lit && !p2_lit)); // R1
    AST_OFF_STATES: assert property (@(posedge clk) disable iff (rst)
        (state_i == 3'd0 || state_i >= 3'd5) |=> (!p1_lit && !p2_lit)); // R6
    AST_DONE_GREEN: assert property (@(posedge clk) disable iff (rst)
        (VARIANT != LED_SINGLE && state_i == 3'd3) |=> (p2_lit && !p1_lit)); // R4
    AST_BICOLOR_FAULT: assert property (@(posedge clk) disable iff (rst)
        (VARIANT == LED_BICOLOR && state_i == 3'd4) |=> (p1_lit && p2_lit)); // R5
    AST_FAULT_ENTRY_LIT: assert property (@(posedge clk) disable iff (rst)
        (state_i == 3'd4 && $past(state_i) != 3'd4) |=> p1_lit); // R8

endmodule

// File: tb/chg_status_led_bench.sv
module chg_status_led_bench;
    import chg_led_pkg::*;

    localparam int HALF = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] state = 3'd0;
    logic [3:0] act [3];
    int         n_vec = 0;
    int         n_bad = 0;
    int         fault_run = 0;
    logic [3:0] exp_q [3];
    logic [2:0] last_state = 3'd0;
    bit         last_rst = 1'b1;
    bit         done_flag = 1'b0;

    always #4 clk = ~clk;

    chg_status_led #(.VARIANT(LED_SINGLE), .BLINK_HALF(HALF)) u_chg_status_led (
        .clk(clk), .rst(rst), .state_i(state),
        .pin1_o(act[0][3]), .pin1_oe(act[0][2]), .pin2_o(act[0][1]), .pin2_oe(act[0][0]));
    chg_status_led #(.VARIANT(LED_DUAL), .BLINK_HALF(HALF)) u_chg_status_led_dual (
        .clk(clk), .rst(rst), .state_i(state),
        .pin1_o(act[1][3]), .pin1_oe(act[1][2]), .pin2_o(act[1][1]), .pin2_oe(act[1][0]));
    chg_status_led #(.VARIANT(LED_BICOLOR), .BLINK_HALF(HALF)) u_chg_status_led_bicolor (
        .clk(clk), .rst(rst), .state_i(state),
        .pin1_o(act[2][3]), .pin1_oe(act[2][2]), .pin2_o(act[2][1]), .pin2_oe(act[2][0]));

    // Expected {pin1_o, pin1_oe, pin2_o, pin2_oe}
    function automatic logic [3:0] exp_pins(int v, logic [2:0] s, bit on, bit r);
        bit l1, l2, chg;
        chg = (s == 3'd1) || (s == 3'd2);
        l1 = 0; l2 = 0;
        if (!r) begin
            if (v == 2) begin
                l1 = chg || s == 3'd4;          // R5
                l2 = s == 3'd3 || s == 3'd4;
            end else begin
                l1 = chg || (s == 3'd4 && on);  // R3 R4 R7
                l2 = (v == 1) && s == 3'd3;
            end
        end
        if (v == 1) return {1'b0, l1, 1'b0, l2};  // R10 open-drain
        return {~l1, 1'b1, ~l2, 1'b1};          // R9 push-pull
    endfunction

    function automatic string tag(int v, logic [2:0] s, bit r);
        if (r) return "R2";
        if (s == 3'd0 || s >= 3'd5) return "R1/R6";
        if (s == 3'd4 && v != 2) return (v == 0) ? "R7/R8/R3/R9" : "R7/R8/R4/R10";
        if (v == 0) return "R1/R3/R9";
        if (v == 1) return "R1/R4/R10";
        return "R1/R5/R9";
    endfunction

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge (R1).
    task automatic step(logic [2:0] s, bit r);
        bit on;
        state = s;
        rst = r;
        if (r || s != 3'd4) begin
            on = 1;
            fault_run = 0;
        end else begin
            on = ((fault_run / HALF) % 2) == 0;
            fault_run++;
        end
        for (int v = 0; v < 3; v++) exp_q[v] = exp_pins(v, s, on, r);
        last_state = s;
        last_rst = r;
        @(posedge clk);
        @(negedge clk);
        for (int v = 0; v < 3; v++) begin
            n_vec++;
            if (act[v] !== exp_q[v]) begin
                n_bad++;
                $display("FAIL %s variant %0d state %0d: actual %b expected %b",
                         tag(v, last_state, last_rst), v, last_state, act[v], exp_q[v]);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R2: reset with active-looking states
        step(3'd4, 1);
        step(3'd1, 1);
        step(3'd3, 1);
        // R1 R3 R4 R5 R6: each code held two cycles
        for (int s = 0; s < 8; s++) begin
            step(3'(s), 0);
            step(3'(s), 0);
        end
        // R7: long fault run over several half periods
        step(3'd2, 0);
        for (int i = 0; i < 4 * HALF + 3; i++) step(3'd4, 0);
        // R8: short burst, leave, re-enter in what would have been the unlit phase
        for (int i = 0; i < HALF + 2; i++) step(3'd4, 0);
        step(3'd7, 0);
        for (int i = 0; i < HALF + 1; i++) step(3'd4, 0);
        step(3'd3, 0);
        step(3'd4, 0);
        // R2: reset in the middle of a fault, then fault again starts lit (R8)
        step(3'd4, 1);
        step(3'd4, 1);
        for (int i = 0; i < 3; i++) step(3'd4, 0);
        // Random runs of states, fault runs biased long
        for (int i = 0; i < 600; i++) begin
            logic [2:0] s;
            int len;
            s = 3'($urandom_range(0, 7));
            len = (s == 3'd4) ? $urandom_range(1, 4 * HALF) : $urandom_range(1, 3);
            for (int k = 0; k < len; k++) step(s, ($urandom_range(0, 199) == 0));
        end
        done_flag = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule